// File: doc/BRIEF.md
# Dual-Port Atomic Reservation Memory

A small word-addressed memory shared by two requesters, each standing in for one hardware thread. Every requester can issue four kinds of access: a plain read, a plain write, a linked read, and a conditional write. A linked read returns the word and records a reservation on that address for the issuing port. A conditional write to the same address succeeds only if no write has reached that word since the linked read. On success it stores the data and returns 1. On failure it stores nothing and returns 0. The status comes back on the read-data lane, in place of the data.

Both requesters share one access slot. Port 0 has fixed priority. Port 1 sees its ready signal drop for any cycle in which port 0 is requesting. A request is taken on the clock edge where its request and ready signals are both high. The response appears one cycle later as a one-cycle valid pulse with the data. Software builds test-and-set locks on these two operations: 0 marks a free lock and 1 marks a held lock.

Top module: `llsc_monitor`

## Requirements
- R1: After reset every memory word reads 0, neither port holds a reservation, and both response valids are low.
- R2: A plain read (op code 0) accepted on a clock edge returns the addressed word on that port's rdata, with rvalid high, in the following cycle.
- R3: A linked read (op code 2) returns the word like a plain read and sets the port's single reservation to that address. A later linked read on the same port replaces the earlier reservation.
- R4: A conditional write (op code 3) whose port holds a reservation on the same address writes wdata and responds with rdata equal to 1.
- R5: A conditional write with no reservation, or with a reservation on a different address, leaves memory unchanged and responds with rdata equal to 0.
- R6: A plain write (op code 1) from either port, including the reserving port, cancels every reservation on the written address.
- R7: A successful conditional write by one port cancels the other port's reservation on that address, so the other port's later conditional write fails.
- R8: A conditional write removes its own port's reservation whether it succeeds or fails.
- R9: When both ports request in the same cycle, only port 0 is accepted: p0_ready is always 1, p1_ready is 0 whenever p0_req is 1, and exactly the accepted port gets a response.
- R10: The response to a conditional write has all bits above bit 0 at zero, and the response to a plain write is all zeros.
- R11: A test-and-set built from a linked read and a conditional write of 1 takes a free lock for exactly one of two competing ports. A port that later does a linked read of the lock word sees 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_req | input | 1 | Port 0 request |
| p0_op | input | 2 | Port 0 operation: 0 read, 1 write, 2 linked read, 3 conditional write |
| p0_addr | input | AW | Port 0 word address |
| p0_wdata | input | DW | Port 0 write data |
| p0_ready | output | 1 | Port 0 accepted when requesting (always 1) |
| p0_rvalid | output | 1 | Port 0 response valid |
| p0_rdata | output | DW | Port 0 read data or conditional-write status |
| p1_req | input | 1 | Port 1 request |
| p1_op | input | 2 | Port 1 operation, same encoding |
| p1_addr | input | AW | Port 1 word address |
| p1_wdata | input | DW | Port 1 write data |
| p1_ready | output | 1 | Port 1 accepted when requesting |
| p1_rvalid | output | 1 | Port 1 response valid |
| p1_rdata | output | DW | Port 1 read data or conditional-write status |

## Verification
Reservation state cannot be seen directly at the ports. A stale or missing reservation bit or address shows up only on that port's next conditional write to the affected word. It appears as a wrong status bit one cycle after acceptance, and as a wrong word on a later read of that address. The bench therefore interleaves linked reads, plain writes and conditional writes from both ports over a handful of addresses. This keeps reservations colliding often, and every status and read value is compared against a reference model. Arbitration faults appear in the same cycle on p1_ready, or one cycle later as a response on the wrong port.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          p0_req,
  input  logic [1:0]    p0_op,
  input  logic [AW-1:0] p0_addr,
  input  logic [DW-1:0] p0_wdata,
  output logic          p0_ready,
  output logic          p0_rvalid,
  output logic [DW-1:0] p0_rdata,
  input  logic          p1_req,
  input  logic [1:0]    p1_op,
  input  logic [AW-1:0] p1_addr,
  input  logic [DW-1:0] p1_wdata,
  output logic          p1_ready,
  output logic          p1_rvalid,
  output logic [DW-1:0] p1_rdata
);
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] OP_WR = 2'd1;
  localparam logic [1:0] OP_LL = 2'd2;
  localparam logic [1:0] OP_SC = 2'd3;

  logic [DW-1:0] mem [DEPTH];
  logic [1:0]    res_v;
  logic [AW-1:0] res_a [2];

  logic          go, sel, sc_ok, do_wr;
  logic [1:0]    op;
  logic [AW-1:0] addr;
  logic [DW-1:0] wd, resp;
  logic [1:0]    rvalid_q;
  logic [DW-1:0] rdata_q;

  assign p0_ready = 1'b1;
  assign p1_ready = ~p0_req;

  assign go   = p0_req | p1_req;
  assign sel  = ~p0_req;
  assign op   = sel ? p1_op    : p0_op;
  assign addr = sel ? p1_addr  : p0_addr;
  assign wd   = sel ? p1_wdata : p0_wdata;

  assign sc_ok = res_v[sel] && (res_a[sel] == addr);
  assign do_wr = go && ((op == OP_WR) || ((op == OP_SC) && sc_ok));

  always_comb begin
    if (op == OP_SC)      resp = {{(DW-1){1'b0}}, sc_ok};
    else if (op == OP_WR) resp = '0;
    else                  resp = mem[addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (do_wr) begin
      mem[addr] <= wd;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_res
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_v[g] <= 1'b0;
        res_a[g] <= '0;
      end else if (go) begin
        if ((op == OP_LL) && (sel == g[0])) begin
          res_v[g] <= 1'b1;
          res_a[g] <= addr;
        end else if (((op == OP_SC) && (sel == g[0])) ||
                     (do_wr && (res_a[g] == addr))) begin
          res_v[g] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 2'b00;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= {go & sel, go & ~sel};
      if (go) rdata_q <= resp;
    end
  end

  assign p0_rvalid = rvalid_q[0];
  assign p1_rvalid = rvalid_q[1];
  assign p0_rdata  = rvalid_q[0] ? rdata_q : '0;
  assign p1_rdata  = rvalid_q[1] ? rdata_q : '0;
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          p0_req,
  input logic [1:0]    p0_op,
  input logic [AW-1:0] p0_addr,
  input logic          p1_req,
  input logic [1:0]    p1_op,
  input logic [AW-1:0] p1_addr,
  input logic          p0_rvalid,
  input logic          p1_rvalid,
  input logic [DW-1:0] p0_rdata,
  input logic [DW-1:0] p1_rdata,
  input logic [1:0]    res_v,
  input logic [AW-1:0] res_a [2]
);
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !armed |-> (!p0_rvalid && !p1_rvalid));

  a_r9_p0_resp: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (p0_rvalid == $past(p0_req)));

  a_r9_p1_resp: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (p1_rvalid == $past(p1_req && !p0_req)));

  a_r9_single_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !(p0_rvalid && p1_rvalid));

  a_r5_sc_unreserved: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_req && p0_op == 2'd3 && !res_v[0]) |=> (p0_rdata == '0));

  a_r8_sc_drops_p0: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_req && p0_op == 2'd3) |=> !res_v[0]);

  a_r8_sc_drops_p1: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_req && !p0_req && p1_op == 2'd3) |=> !res_v[1]);

  a_r6_p1_store_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_req && !p0_req && p1_op == 2'd1 && res_v[0] && res_a[0] == p1_addr)
      |=> !res_v[0]);

  a_r6_p0_store_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_req && p0_op == 2'd1 && res_v[1] && res_a[1] == p0_addr)
      |=> !res_v[1]);

  a_r10_p0_status: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_req && p0_op == 2'd3) |=> (p0_rdata[DW-1:1] == '0));

  a_r10_p1_status: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_req && !p0_req && p1_op == 2'd3) |=> (p1_rdata[DW-1:1] == '0));
endmodule

bind llsc_monitor llsc_monitor_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .p0_req(p0_req), .p0_op(p0_op), .p0_addr(p0_addr),
  .p1_req(p1_req), .p1_op(p1_op), .p1_addr(p1_addr),
  .p0_rvalid(p0_rvalid), .p1_rvalid(p1_rvalid),
  .p0_rdata(p0_rdata), .p1_rdata(p1_rdata),
  .res_v(res_v), .res_a(res_a)
);

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n;
  logic p0_req, p1_req, p0_ready, p1_ready, p0_rvalid, p1_rvalid;
  logic [1:0] p0_op, p1_op;
  logic [AW-1:0] p0_addr, p1_addr;
  logic [DW-1:0] p0_wdata, p1_wdata, p0_rdata, p1_rdata;

  llsc_monitor #(.AW(AW), .DW(DW)) u_llsc_monitor (.*);

  int n_tests = 0;
  int n_fail = 0;

  logic [DW-1:0] m_mem [DEPTH];
  bit            m_rv [2];
  logic [AW-1:0] m_ra [2];
  bit            e_v [2];
  logic [DW-1:0] e_d [2];
  string         e_tag [2];

  function automatic logic [DW-1:0] model_apply(int p, logic [1:0] op,
                                                logic [AW-1:0] a, logic [DW-1:0] d);
    logic [DW-1:0] r = '0;
    bit ok;
    case (op)
      2'd0: r = m_mem[a];
      2'd1: begin
        m_mem[a] = d;
        for (int q = 0; q < 2; q++) if (m_ra[q] == a) m_rv[q] = 0;
      end
      2'd2: begin
        r = m_mem[a];
        m_rv[p] = 1;
        m_ra[p] = a;
      end
      default: begin
        ok = m_rv[p] && (m_ra[p] == a);
        if (ok) begin
          m_mem[a] = d;
          for (int q = 0; q < 2; q++) if (m_ra[q] == a) m_rv[q] = 0;
        end
        m_rv[p] = 0;
        r = {{(DW-1){1'b0}}, ok};
      end
    endcase
    return r;
  endfunction

  function automatic string op_tag(logic [1:0] op, logic [DW-1:0] r);
    case (op)
      2'd0: return "R2";
      2'd1: return "R10";
      2'd2: return "R3";
      default: return r[0] ? "R4" : "R5";
    endcase
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(bit r0, logic [1:0] o0, logic [AW-1:0] a0, logic [DW-1:0] d0,
                      bit r1, logic [1:0] o1, logic [AW-1:0] a1, logic [DW-1:0] d1,
                      string tag);
    logic [DW-1:0] r;
    @(negedge clk);
    check({e_tag[0], " p0 rvalid"}, p0_rvalid, e_v[0]);
    if (e_v[0]) check({e_tag[0], " p0 rdata"}, p0_rdata, e_d[0]);
    check({e_tag[1], " p1 rvalid"}, p1_rvalid, e_v[1]);
    if (e_v[1]) check({e_tag[1], " p1 rdata"}, p1_rdata, e_d[1]);
    p0_req = r0; p0_op = o0; p0_addr = a0; p0_wdata = d0;
    p1_req = r1; p1_op = o1; p1_addr = a1; p1_wdata = d1;
    #1;
    check("R9 p0_ready", p0_ready, 1'b1);
    check("R9 p1_ready", p1_ready, !r0);
    e_v[0] = 0; e_v[1] = 0;
    if (r0) begin
      r = model_apply(0, o0, a0, d0);
      e_v[0] = 1; e_d[0] = r;
      e_tag[0] = (tag != "") ? tag : op_tag(o0, r);
    end else if (r1) begin
      r = model_apply(1, o1, a1, d1);
      e_v[1] = 1; e_d[1] = r;
      e_tag[1] = (tag != "") ? tag : op_tag(o1, r);
    end
  endtask

  task automatic s0(logic [1:0] o, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    step(1, o, a, d, 0, 2'd0, '0, '0, tag);
  endtask

  task automatic s1(logic [1:0] o, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    step(0, 2'd0, '0, '0, 1, o, a, d, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0;
    p0_req = 0; p0_op = 0; p0_addr = 0; p0_wdata = 0;
    p1_req = 0; p1_op = 0; p1_addr = 0; p1_wdata = 0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    for (int q = 0; q < 2; q++) begin
      m_rv[q] = 0; m_ra[q] = '0; e_v[q] = 0; e_d[q] = '0; e_tag[q] = "R1";
    end
    repeat (3) @(posedge clk);
    rst_n = 1;

    // R1: reset state
    for (int i = 0; i < 4; i++) s0(2'd0, AW'(i), '0, "R1");
    s1(2'd0, AW'(15), '0, "R1");
    // R4 then R8
    s0(2'd2, 5, 0, "");
    s0(2'd3, 5, 77, "R4");
    s1(2'd0, 5, 0, "R4");
    s0(2'd3, 5, 88, "R8");
    s0(2'd0, 5, 0, "R8");
    // R5: no reservation, address mismatch
    s0(2'd3, 6, 9, "R5");
    s0(2'd0, 6, 0, "R5");
    s1(2'd2, 7, 0, "");
    s1(2'd3, 8, 4, "R5");
    s1(2'd0, 8, 0, "R5");
    // R6: store by other port, and by own port
    s0(2'd2, 9, 0, "");
    s1(2'd1, 9, 55, "R10");
    s0(2'd3, 9, 99, "R6");
    s0(2'd0, 9, 0, "R6");
    s0(2'd2, 10, 0, "");
    s0(2'd1, 10, 3, "");
    s0(2'd3, 10, 4, "R6");
    // R3: second linked read replaces the first
    s0(2'd2, 2, 0, "");
    s0(2'd2, 3, 0, "");
    s0(2'd3, 2, 1, "R3");
    s0(2'd3, 3, 1, "R3");
    // R7 and R11: competing test-and-set on lock word 12
    s0(2'd2, 12, 0, "R11");
    s1(2'd2, 12, 0, "R11");
    s1(2'd3, 12, 1, "R11");
    s0(2'd3, 12, 1, "R7");
    s0(2'd2, 12, 0, "R11");
    s1(2'd1, 12, 0, "");
    // R9: simultaneous requests
    step(1, 2'd0, 12, 0, 1, 2'd1, 12, 5, "R9");
    step(1, 2'd2, 12, 0, 1, 2'd2, 12, 0, "R9");
    s1(2'd0, 12, 0, "R9");

    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 10) < 6, 2'($urandom), 2'($urandom), $urandom % 4,
           ($urandom % 10) < 8, 2'($urandom), 2'($urandom), $urandom % 4, "");
    end
    step(0, 2'd0, '0, '0, 0, 2'd0, '0, '0, "");
    step(0, 2'd0, '0, '0, 0, 2'd0, '0, '0, "");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule